// File: doc/BRIEF.md
# Two-Channel Converter Data Front End

This block sits between a data source and a pair of 8-bit converter cores. It
turns parallel input words into two registered output codes, one per
converter. Every channel is double-buffered. A load strobe first captures a
word into a staging register. A separate update strobe then moves the staged
word into the output register that drives the converter. This lets a source
write each channel at its own pace and choose when the analog outputs step.

A mode input selects between two ways of working.

- **Two-port mode:** each channel has its own data bus, load strobe and update strobe.
- **Single-stream mode:** the two control pairs change meaning. Words arrive on port A only, and a two-state phase machine steers them alternately into the I staging register (channel A) and the Q staging register (channel B). One strobe moves both staged words to the outputs together, so the outputs step at half the incoming word rate.

A pause input stops every output update but lets the staging registers keep loading. All strobes are synchronous enables sampled on the rising edge of `clk`.

The phase machine has two states.

- **State `PH_I`:** the next word goes to I.
- **State `PH_Q`:** the next word goes to Q.

Its transitions are:

- **`T_IQ`:** a plain write in `PH_I` stores the word to I and moves to `PH_Q`.
- **`T_QI`:** a write in `PH_Q` stores the word to Q and moves to `PH_I`.
- **`T_SEL`:** a write with the select high stores the word to Q and moves to `PH_I`.
- **`T_ALIGN`:** a write during the realign strobe stores the word to I and moves to `PH_Q`.
- **`T_ALIGN_IDLE`:** the realign strobe without a write moves to `PH_I`.
- **`T_PARK`:** two-port mode holds the machine in `PH_I`.

Top module: `dacif_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, all staging and output registers become mid-scale 0x80. The phase machine also returns to `PH_I`. Both codes read 0x80 after that edge.
- R2: In two-port mode (`dual_mode`=1), `stb_a` loads `din_a` into staging A. `code_a` takes the staged value only at an edge where `upd_a` is high. When both strobes are high at the same edge, `code_a` takes the value staged before that edge.
- R3: In two-port mode, `stb_b`, `din_b` and `upd_b` load channel B in the same way as R2. They never change channel A, and channel A's strobes never change channel B.
- R4: In two-port mode, `upd_a` and `upd_b` high at the same edge change both codes at that same edge.
- R5: In single-stream mode (`dual_mode`=0) with `stb_b` (select) low, successive writes on `stb_a` take `din_a` alternately into I (channel A) and Q (channel B). The sequence starts with I after reset.
- R6: In single-stream mode, `upd_b` acts as the realign strobe. Without a write, it sets the phase to I. If a write happens at the same edge, that word goes to I and the following word goes to Q.
- R7: In single-stream mode, a write with `stb_b` (select) high goes to Q whatever the phase, and the following plain write goes to I.
- R8: In single-stream mode, `upd_a` moves both staged words to both codes at the same edge, and `upd_b` updates no code.
- R9: In single-stream mode, `din_b` is ignored.
- R10: While `pause` is high, neither code changes in either mode. Staging registers still load, and their values appear at the first update after `pause` falls.
- R11: Time spent in two-port mode leaves the phase at I, so the first single-stream write after a return goes to I.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all registers |
| rst_n | input | 1 | Synchronous active-low reset |
| dual_mode | input | 1 | 1 = two-port mode, 0 = single-stream mode |
| din_a | input | 8 | Port A data, bit 7 MSB; the only data port in single-stream mode |
| din_b | input | 8 | Port B data, bit 7 MSB; ignored in single-stream mode |
| stb_a | input | 1 | Two-port: load staging A. Single-stream: stream write |
| upd_a | input | 1 | Two-port: update code A. Single-stream: update both codes |
| upd_b | input | 1 | Two-port: update code B. Single-stream: realign phase to I |
| stb_b | input | 1 | Two-port: load staging B. Single-stream: route word to Q |
| pause | input | 1 | Blocks all output-register updates |
| code_a | output | 8 | Channel A (I) converter code |
| code_b | output | 8 | Channel B (Q) converter code |

## Verification
Two pairs of functions can coincide in one cycle.

- **Load and update:** a load and an update can hit the same channel at the same edge. The bench drives `stb_a` and `upd_a` together and expects the previously staged word on the output, not the new one.
- **Realign and write:** in single-stream mode, the realign strobe can arrive together with a write. The bench expects that word in I and the next word in Q.

A behavioural model in the bench, driven by the same stimulus, produces the expected codes after every edge. This covers directed sequences and a long pseudo-random run that toggles mode, pause and all strobes.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
    typedef enum logic [0:0] {
        PH_I = 1'b0,
        PH_Q = 1'b1
    } iq_phase_e;

    localparam int NUM_CH = 2;
    localparam int CH_I   = 0;
    localparam int CH_Q   = 1;
endpackage

// File: rtl/dacif_phase_fsm.sv
module dacif_phase_fsm
    import dacif_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stream_mode,
    input  logic      wr,
    input  logic      realign,
    input  logic      sel_q,
    output logic      to_q,
    output iq_phase_e phase
);
    iq_phase_e state_q;
    iq_phase_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_I;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and steering output
    always_comb begin
        state_d = state_q;
        to_q    = 1'b0;
        if (!stream_mode) begin
            state_d = PH_I;                       // T_PARK
        end else begin
            unique case (state_q)
                PH_I: begin
                    if (wr) begin
                        if (realign) begin
                            state_d = PH_Q;       // T_ALIGN
                        end else if (sel_q) begin
                            to_q    = 1'b1;       // T_SEL
                            state_d = PH_I;
                        end else begin
                            state_d = PH_Q;       // T_IQ
                        end
                    end else begin
                        state_d = PH_I;
                    end
                end
                PH_Q: begin
                    if (wr) begin
                        if (realign) begin
                            state_d = PH_Q;       // T_ALIGN
                        end else begin
                            to_q    = 1'b1;       // T_QI or T_SEL
                            state_d = PH_I;
                        end
                    end else if (realign) begin
                        state_d = PH_I;           // T_ALIGN_IDLE
                    end else begin
                        state_d = PH_Q;
                    end
                end
                default: state_d = PH_I;
            endcase
        end
    end

    assign phase = state_q;
endmodule

// File: rtl/dacif_chan.sv
module dacif_chan #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_stage,
    input  logic [DW-1:0] stage_in,
    input  logic          load_out,
    output logic [DW-1:0] code
);
    localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

    logic [DW-1:0] stage_q;
    logic [DW-1:0] out_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= MID;
        end else if (load_stage) begin
            stage_q <= stage_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= MID;
        end else if (load_out) begin
            out_q <= stage_q;
        end
    end

    assign code = out_q;
endmodule

// File: rtl/dacif_top.sv
module dacif_top
    import dacif_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dual_mode,
    input  logic [DW-1:0] din_a,
    input  logic [DW-1:0] din_b,
    input  logic          stb_a,
    input  logic          upd_a,
    input  logic          upd_b,
    input  logic          stb_b,
    input  logic          pause,
    output logic [DW-1:0] code_a,
    output logic [DW-1:0] code_b
);
    logic      stream_mode;
    logic      to_q;
    iq_phase_e phase_q;

    logic [NUM_CH-1:0]         ld_stage;
    logic [NUM_CH-1:0]         ld_out;
    logic [NUM_CH-1:0][DW-1:0] stage_din;
    logic [NUM_CH-1:0][DW-1:0] codes;

    assign stream_mode = !dual_mode;

    dacif_phase_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .stream_mode(stream_mode),
        .wr         (stb_a),
        .realign    (upd_b),
        .sel_q      (stb_b),
        .to_q       (to_q),
        .phase      (phase_q)
    );

    // steering of loads and updates per mode
    always_comb begin
        if (dual_mode) begin
            ld_stage[CH_I]  = stb_a;
            ld_stage[CH_Q]  = stb_b;
            stage_din[CH_I] = din_a;
            stage_din[CH_Q] = din_b;
            ld_out[CH_I]    = upd_a && !pause;
            ld_out[CH_Q]    = upd_b && !pause;
        end else begin
            ld_stage[CH_I]  = stb_a && !to_q;
            ld_stage[CH_Q]  = stb_a && to_q;
            stage_din[CH_I] = din_a;
            stage_din[CH_Q] = din_a;
            ld_out[CH_I]    = upd_a && !pause;
            ld_out[CH_Q]    = upd_a && !pause;
        end
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        dacif_chan #(.DW(DW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_stage(ld_stage[ch]),
            .stage_in  (stage_din[ch]),
            .load_out  (ld_out[ch]),
            .code      (codes[ch])
        );
    end

    assign code_a = codes[CH_I];
    assign code_b = codes[CH_Q];
endmodule

// File: rtl/dacif_checker.sv
module dacif_checker
    import dacif_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dual_mode,
    input logic          stb_a,
    input logic          upd_a,
    input logic          upd_b,
    input logic          pause,
    input logic [DW-1:0] code_a,
    input logic [DW-1:0] code_b,
    input iq_phase_e     phase
);
    localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

    logic rst_seen = 1'b0;
    always_ff @(posedge clk) rst_seen <= !rst_n;

    always @(negedge clk) begin
        if (rst_seen) begin
            assert_reset_mid_R1: assert (code_a == MID && code_b == MID);
        end
    end

    assert_a_needs_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_a |=> $stable(code_a));

    assert_b_needs_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(dual_mode ? upd_b : upd_a) |=> $stable(code_b));

    assert_realign_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_mode && upd_b && !stb_a) |=> (phase == PH_I));

    assert_realign_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_mode && upd_b && stb_a) |=> (phase == PH_Q));

    assert_pause_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pause |=> ($stable(code_a) && $stable(code_b)));

    assert_park_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dual_mode |=> (phase == PH_I));
endmodule

bind dacif_top dacif_checker #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dual_mode(dual_mode),
    .stb_a    (stb_a),
    .upd_a    (upd_a),
    .upd_b    (upd_b),
    .pause    (pause),
    .code_a   (code_a),
    .code_b   (code_b),
    .phase    (phase_q)
);

// File: tb/dacif_top_bench.sv
module dacif_top_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dual_mode = 1'b1;
    logic [7:0] din_a = 8'h00;
    logic [7:0] din_b = 8'h00;
    logic       stb_a = 1'b0, upd_a = 1'b0, upd_b = 1'b0, stb_b = 1'b0, pause = 1'b0;
    logic [7:0] code_a, code_b;

    always #(CLK_PERIOD/2) clk = ~clk;

    dacif_top u_dacif_top (
        .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode),
        .din_a(din_a), .din_b(din_b), .stb_a(stb_a), .upd_a(upd_a),
        .upd_b(upd_b), .stb_b(stb_b), .pause(pause),
        .code_a(code_a), .code_b(code_b)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // behavioural model state
    int m_st_i = 128, m_st_q = 128, m_out_i = 128, m_out_q = 128;
    int m_next_is_q = 0;

    task automatic model_step();
        int ni = m_st_i, nq = m_st_q, oi = m_out_i, oq = m_out_q, np = m_next_is_q;
        if (!rst_n) begin
            ni = 128; nq = 128; oi = 128; oq = 128; np = 0;
        end else if (dual_mode) begin
            if (stb_a) ni = din_a;
            if (stb_b) nq = din_b;
            if (upd_a && !pause) oi = m_st_i;
            if (upd_b && !pause) oq = m_st_q;
            np = 0;
        end else begin
            if (stb_a) begin
                if (upd_b)             begin ni = din_a; np = 1; end
                else if (stb_b)        begin nq = din_a; np = 0; end
                else if (m_next_is_q == 0) begin ni = din_a; np = 1; end
                else                   begin nq = din_a; np = 0; end
            end else if (upd_b) begin
                np = 0;
            end
            if (upd_a && !pause) begin oi = m_st_i; oq = m_st_q; end
        end
        m_st_i = ni; m_st_q = nq; m_out_i = oi; m_out_q = oq; m_next_is_q = np;
    endtask

    task automatic compare(input string tag);
        checks++;
        if (code_a !== m_out_i[7:0]) begin
            failures++;
            $display("FAIL %s code_a actual=%02h expected=%02h t=%0t", tag, code_a, m_out_i[7:0], $time);
        end
        checks++;
        if (code_b !== m_out_q[7:0]) begin
            failures++;
            $display("FAIL %s code_b actual=%02h expected=%02h t=%0t", tag, code_b, m_out_q[7:0], $time);
        end
    endtask

    task automatic cyc(input bit d, input logic [7:0] pa, input logic [7:0] pb,
                       input bit sa, input bit ua, input bit ub, input bit sb,
                       input bit ps, input string tag);
        @(negedge clk);
        dual_mode = d; din_a = pa; din_b = pb;
        stb_a = sa; upd_a = ua; upd_b = ub; stb_b = sb; pause = ps;
        @(posedge clk);
        model_step();
        #1;
        compare(tag);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        // R1: reset to mid-scale
        rst_n = 1'b0;
        cyc(1, 8'h00, 8'h00, 0, 0, 0, 0, 0, "R1");
        cyc(1, 8'h00, 8'h00, 1, 1, 1, 1, 0, "R1");
        rst_n = 1'b1;
        cyc(1, 8'h00, 8'h00, 0, 1, 1, 0, 0, "R1");

        // R2: double buffering on channel A
        cyc(1, 8'h11, 8'h00, 1, 0, 0, 0, 0, "R2");
        cyc(1, 8'h00, 8'h00, 0, 1, 0, 0, 0, "R2");
        cyc(1, 8'h22, 8'h00, 1, 1, 0, 0, 0, "R2");
        cyc(1, 8'h00, 8'h00, 0, 1, 0, 0, 0, "R2");

        // R3: channel B independent
        cyc(1, 8'hAA, 8'h33, 0, 0, 0, 1, 0, "R3");
        cyc(1, 8'hAA, 8'h00, 0, 0, 1, 0, 0, "R3");
        cyc(1, 8'h5A, 8'hA5, 1, 0, 0, 0, 0, "R3");
        cyc(1, 8'h00, 8'h00, 0, 0, 1, 0, 0, "R3");

        // R4: simultaneous update
        cyc(1, 8'h01, 8'hFE, 1, 0, 0, 1, 0, "R4");
        cyc(1, 8'h00, 8'h00, 0, 1, 1, 0, 0, "R4");

        // R10: pause in two-port mode
        cyc(1, 8'h44, 8'h55, 1, 1, 1, 1, 1, "R10");
        cyc(1, 8'h00, 8'h00, 0, 1, 1, 0, 1, "R10");
        cyc(1, 8'h00, 8'h00, 0, 1, 1, 0, 0, "R10");

        // R5, R8, R9: stream alternation and joint update
        cyc(0, 8'h50, 8'hEE, 1, 0, 0, 0, 0, "R5");
        cyc(0, 8'h60, 8'hDD, 1, 0, 0, 0, 0, "R9");
        cyc(0, 8'h00, 8'hCC, 0, 0, 1, 0, 0, "R8");
        cyc(0, 8'h00, 8'hBB, 0, 1, 0, 0, 0, "R8");

        // R6: realign idle and realign with write
        cyc(0, 8'h70, 8'h00, 1, 0, 0, 0, 0, "R6");
        cyc(0, 8'h00, 8'h00, 0, 0, 1, 0, 0, "R6");
        cyc(0, 8'h71, 8'h00, 1, 0, 0, 0, 0, "R6");
        cyc(0, 8'h72, 8'h00, 1, 0, 0, 0, 0, "R6");
        cyc(0, 8'h00, 8'h00, 0, 1, 0, 0, 0, "R6");
        cyc(0, 8'h73, 8'h00, 1, 0, 0, 0, 0, "R6");
        cyc(0, 8'h74, 8'h00, 1, 0, 1, 0, 0, "R6");
        cyc(0, 8'h75, 8'h00, 1, 0, 0, 0, 0, "R6");
        cyc(0, 8'h00, 8'h00, 0, 1, 0, 0, 0, "R6");

        // R7: select forces Q
        cyc(0, 8'h81, 8'h00, 1, 0, 0, 1, 0, "R7");
        cyc(0, 8'h82, 8'h00, 1, 0, 0, 0, 0, "R7");
        cyc(0, 8'h00, 8'h00, 0, 1, 0, 0, 0, "R7");

        // R10: pause in stream mode
        cyc(0, 8'h91, 8'h00, 1, 0, 0, 0, 0, "R10");
        cyc(0, 8'h92, 8'h00, 1, 1, 0, 0, 1, "R10");
        cyc(0, 8'h00, 8'h00, 0, 1, 0, 0, 0, "R10");

        // R11: park in two-port mode resets phase
        cyc(0, 8'hA1, 8'h00, 1, 0, 0, 0, 0, "R11");
        cyc(1, 8'h00, 8'h00, 0, 0, 0, 0, 0, "R11");
        cyc(0, 8'hA2, 8'h00, 1, 0, 0, 0, 0, "R11");
        cyc(0, 8'h00, 8'h00, 0, 1, 0, 0, 0, "R11");

        // mixed pseudo-random traffic
        lfsr = 16'hACE1;
        for (int i = 0; i < 2000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[15] & lfsr[14], lfsr[7:0], {lfsr[3:0], lfsr[11:8]},
                lfsr[0], lfsr[1], lfsr[2] & lfsr[9], lfsr[3] & lfsr[8],
                lfsr[4] & lfsr[5], "R5");
        end

        // R1 again mid-stream
        rst_n = 1'b0;
        cyc(0, 8'h00, 8'h00, 1, 1, 0, 0, 0, "R1");
        rst_n = 1'b1;
        cyc(0, 8'h00, 8'h00, 0, 1, 0, 0, 0, "R1");

        finish_run();
    end
endmodule